// File: doc/BRIEF.md
# Triple-Modulus Programmable Prescaler

This block is a synchronous frequency divider for the feedback path of a PLL synthesizer. It divides its input clock by 64, 65 or 72. Two select inputs choose the ratio. Internally, a front stage that divides by four or five feeds a second-stage counter. The second-stage counter advances once for each pass of the front stage. The ratio comes from two things: the length of that counter, and whether the front stage stretches its final pass to five input clocks.

The block produces one output pulse shape per division cycle. The output is low from the final input count of a cycle through count 31 of the next cycle. It is high from count 32 until the final count. The select inputs are captured once per cycle, on the edge that ends it. A change made part-way through a cycle therefore governs the whole of the following cycle and never disturbs the cycle in progress. A debug output reports the current input-count index, from 1 to N, so the edge positions and the cycle lengths can be observed directly.

Top module: `tmod_prescaler`

## Requirements
- R1: With sel_wide=0 and sel_fine=1, each division cycle is 64 input clocks long: 16 front-stage passes of 4 clocks each.
- R2: With sel_wide=0 and sel_fine=0, each cycle is 65 clocks long. The last front-stage pass of the cycle takes 5 clocks and all the others take 4.
- R3: With sel_wide=1, each cycle is 72 clocks long whatever the value of sel_fine: 18 passes of 4 clocks each.
- R4: count_idx advances by exactly one on every rising clock edge outside reset. After reaching the current cycle length N, it returns to 1.
- R5: div_out is low while count_idx is 1 to 31 and while count_idx equals N. It is high while count_idx is 32 to N-1. It therefore rises on entering count 32 and falls on entering count N.
- R6: The selects are sampled only on the edge that ends a cycle, which is the edge leaving count N. Any values they take at other times have no effect on the cycle length.
- R7: While rst is high at a rising edge, the block goes to count_idx=1 with div_out low. The first cycle after reset uses the select value present at the last reset edge.
- R8: When the ratio changes between consecutive cycles, in any direction among 64, 65 and 72, the first cycle after the change has exactly the new length.
- R9: The divider is fully static. If the clock stops for any length of time, count_idx and div_out hold their values, and counting resumes correctly afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided; the block acts on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sel_fine | input | 1 | With sel_wide low: 1 selects divide-by-64, 0 selects divide-by-65 |
| sel_wide | input | 1 | 1 selects divide-by-72 |
| div_out | output | 1 | Registered divided output |
| count_idx | output | 7 | Debug: current input-count index within the cycle, 1 to N |

## Verification
On every cycle, the bound checker confirms four things: count_idx steps by one or wraps to 1 only after a legal cycle length; the output rises only at count 32 and falls only at a final count; the output is low at count 1; and reset leaves the block at count 1 with the output low. Only the bench's scenarios can show that a given select value produces the matching length. The bench's scenarios also show that select values changed mid-cycle are ignored, that every switch between ratios lands exactly, and that a stopped clock freezes the state.

// File: rtl/tmod_pkg.sv
package tmod_pkg;
   typedef enum logic [1:0] {
      MOD_BASE    = 2'd0,
      MOD_SWALLOW = 2'd1,
      MOD_WIDE    = 2'd2
   } mod_e;
endpackage

// File: rtl/tmod_mod_decode.sv
module tmod_mod_decode
   import tmod_pkg::*;
(
   input  logic sel_fine,
   input  logic sel_wide,
   output mod_e mode
);
   always_comb begin
      if (sel_wide)      mode = MOD_WIDE;
      else if (sel_fine) mode = MOD_BASE;
      else               mode = MOD_SWALLOW;
   end
endmodule

// File: rtl/tmod_front_stage.sv
module tmod_front_stage #(
   parameter int BASE = 4,
   localparam int W = $clog2(BASE + 1)
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         stretch,
   output logic [W-1:0] cnt,
   output logic         wrap
);
   logic [W-1:0] last_val;

   assign last_val = stretch ? W'(BASE) : W'(BASE - 1);
   assign wrap     = (cnt == last_val);

   always_ff @(posedge clk) begin
      if (rst)       cnt <= '0;
      else if (wrap) cnt <= '0;
      else           cnt <= cnt + W'(1);
   end
endmodule

// File: rtl/tmod_back_stage.sv
module tmod_back_stage #(
   parameter int LEN_SHORT = 16,
   parameter int LEN_LONG  = 18,
   localparam int W = $clog2(LEN_LONG)
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         adv,
   input  logic         long_len,
   output logic [W-1:0] cnt,
   output logic         at_last
);
   assign at_last = long_len ? (cnt == W'(LEN_LONG - 1)) : (cnt == W'(LEN_SHORT - 1));

   always_ff @(posedge clk) begin
      if (rst)          cnt <= '0;
      else if (adv) begin
         if (at_last)   cnt <= '0;
         else           cnt <= cnt + W'(1);
      end
   end
endmodule

// File: rtl/tmod_prescaler.sv
module tmod_prescaler
   import tmod_pkg::*;
#(
   parameter int FRONT_DIV  = 4,
   parameter int BACK_LEN   = 16,
   parameter int BACK_EXTRA = 2,
   parameter int RISE_AT    = 32,
   parameter bit REG_OUT    = 1'b1,
   localparam int N_BASE    = BACK_LEN * FRONT_DIV,
   localparam int N_SWALLOW = N_BASE + 1,
   localparam int N_WIDE    = (BACK_LEN + BACK_EXTRA) * FRONT_DIV,
   localparam int IDX_W     = $clog2(N_WIDE + 1),
   localparam int FW        = $clog2(FRONT_DIV + 1),
   localparam int BW        = $clog2(BACK_LEN + BACK_EXTRA)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             sel_fine,
   input  logic             sel_wide,
   output logic             div_out,
   output logic [IDX_W-1:0] count_idx
);
   if (FRONT_DIV < 2) begin : g_bad_front
      $error("FRONT_DIV must be at least 2");
   end
   if (BACK_LEN < 2 || BACK_EXTRA < 1) begin : g_bad_back
      $error("BACK_LEN must be at least 2 and BACK_EXTRA at least 1");
   end
   if (RISE_AT < 2 || RISE_AT >= N_BASE) begin : g_bad_rise
      $error("RISE_AT must lie inside the shortest cycle");
   end

   mod_e             mode_in, mode_q;
   logic [FW-1:0]    front_cnt;
   logic [BW-1:0]    back_cnt;
   logic             front_wrap, back_last, stretch, cycle_end;
   logic [IDX_W-1:0] cur_len;

   tmod_mod_decode u_dec (
      .sel_fine (sel_fine),
      .sel_wide (sel_wide),
      .mode     (mode_in)
   );

   // Swallow one extra input clock only on the final pass of a 65 cycle.
   assign stretch   = (mode_q == MOD_SWALLOW) && (back_cnt == BW'(BACK_LEN - 1));
   assign cycle_end = front_wrap && back_last;

   tmod_front_stage #(.BASE(FRONT_DIV)) u_front (
      .clk     (clk),
      .rst     (rst),
      .stretch (stretch),
      .cnt     (front_cnt),
      .wrap    (front_wrap)
   );

   tmod_back_stage #(.LEN_SHORT(BACK_LEN), .LEN_LONG(BACK_LEN + BACK_EXTRA)) u_back (
      .clk      (clk),
      .rst      (rst),
      .adv      (front_wrap),
      .long_len (mode_q == MOD_WIDE),
      .cnt      (back_cnt),
      .at_last  (back_last)
   );

   // Selects are captured during reset and on the edge that closes a cycle.
   always_ff @(posedge clk) begin
      if (rst || cycle_end) mode_q <= mode_in;
   end

   always_comb begin
      case (mode_q)
         MOD_SWALLOW: cur_len = IDX_W'(N_SWALLOW);
         MOD_WIDE:    cur_len = IDX_W'(N_WIDE);
         default:     cur_len = IDX_W'(N_BASE);
      endcase
   end

   assign count_idx = IDX_W'(back_cnt) * IDX_W'(FRONT_DIV) + IDX_W'(front_cnt) + IDX_W'(1);

   if (REG_OUT) begin : g_out_reg
      logic out_q;
      always_ff @(posedge clk) begin
         if (rst)                                  out_q <= 1'b0;
         else if (count_idx == cur_len - IDX_W'(1)) out_q <= 1'b0;
         else if (count_idx == IDX_W'(RISE_AT - 1)) out_q <= 1'b1;
      end
      assign div_out = out_q;
   end else begin : g_out_comb
      assign div_out = (count_idx >= IDX_W'(RISE_AT)) && (count_idx < cur_len);
   end
endmodule

// File: rtl/tmod_prescaler_chk.sv
module tmod_prescaler_chk #(
   parameter int RISE_AT = 32,
   parameter int N_A     = 64,
   parameter int N_B     = 65,
   parameter int N_C     = 72,
   parameter int IW      = 7
) (
   input logic          clk,
   input logic          rst,
   input logic          div_out,
   input logic [IW-1:0] count_idx
);
   assert_idx_range_R4: assert property (@(posedge clk) disable iff (rst)
      (count_idx >= IW'(1)) && (count_idx <= IW'(N_C)));

   assert_idx_step_R4: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> ((count_idx == $past(count_idx) + IW'(1)) ||
                       ((count_idx == IW'(1)) && ($past(count_idx) >= IW'(N_A)))));

   // R1 R2 R3 R8: a cycle may only close after one of the legal lengths.
   assert_wrap_len_R8: assert property (@(posedge clk) disable iff (rst)
      ((count_idx == IW'(1)) && !$past(rst)) |->
         (($past(count_idx) == IW'(N_A)) || ($past(count_idx) == IW'(N_B)) ||
          ($past(count_idx) == IW'(N_C))));

   assert_low_at_start_R5: assert property (@(posedge clk) disable iff (rst)
      (count_idx == IW'(1)) |-> !div_out);

   assert_rise_pos_R5: assert property (@(posedge clk) disable iff (rst)
      $rose(div_out) |-> (count_idx == IW'(RISE_AT)));

   assert_fall_pos_R5: assert property (@(posedge clk) disable iff (rst)
      $fell(div_out) |-> (count_idx >= IW'(N_A)));

   assert_reset_state_R7: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> ((count_idx == IW'(1)) && !div_out));
endmodule

bind tmod_prescaler tmod_prescaler_chk #(
   .RISE_AT (RISE_AT),
   .N_A     (N_BASE),
   .N_B     (N_SWALLOW),
   .N_C     (N_WIDE),
   .IW      (IDX_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .div_out   (div_out),
   .count_idx (count_idx)
);

// File: tb/sim_tmod_prescaler.sv
module sim_tmod_prescaler;
   logic       clk = 1'b0;
   logic       clk_en = 1'b1;
   logic       rst = 1'b1;
   logic       sel_fine = 1'b1;
   logic       sel_wide = 1'b0;
   logic       div_out;
   logic [6:0] count_idx;

   typedef struct {
      int    idx;
      bit    out;
      string tag;
   } exp_t;

   exp_t q[$];
   int   n_run = 0;
   int   n_fail = 0;
   bit   mon_en = 1'b0;
   bit   done = 1'b0;

   logic [1:0] seq [10] = '{2'b01, 2'b01, 2'b00, 2'b10, 2'b01,
                            2'b11, 2'b00, 2'b00, 2'b01, 2'b10};

   tmod_prescaler u0 (
      .clk       (clk),
      .rst       (rst),
      .sel_fine  (sel_fine),
      .sel_wide  (sel_wide),
      .div_out   (div_out),
      .count_idx (count_idx)
   );

   // 200 MHz clock that can be halted to show static operation.
   always begin
      #2.5;
      if (clk_en) clk = ~clk;
   end

   task automatic check(string tag, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // sel encoding {sel_wide, sel_fine}: 1x -> 72, 01 -> 64, 00 -> 65
   function automatic int len_of(logic [1:0] s);
      if (s[1])      return 72;
      else if (s[0]) return 64;
      else           return 65;
   endfunction

   function automatic string mode_tag(logic [1:0] s);
      if (s[1])      return "R3";
      else if (s[0]) return "R1";
      else           return "R2";
   endfunction

   task automatic push_cycle(logic [1:0] s, string tag);
      int n = len_of(s);
      for (int i = 1; i <= n; i++) begin
         exp_t e;
         e.idx = i;
         e.out = (i >= 32) && (i < n);
         e.tag = tag;
         q.push_back(e);
      end
   endtask

   task automatic wait_idx(int v);
      do @(negedge clk); while (count_idx != 7'(v));
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
   endtask

   // Monitor: pops one expected item per clock and compares at the falling edge.
   always @(negedge clk) begin
      if (mon_en && !rst && q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         check({e.tag, " R4 idx"}, int'(count_idx), e.idx);
         check({e.tag, " R5 out"}, int'(div_out), int'(e.out));
      end
   end

   initial begin
      string t;
      {sel_wide, sel_fine} = seq[0];
      repeat (3) @(negedge clk);
      check("R7 reset idx", int'(count_idx), 1);
      check("R7 reset out", int'(div_out), 0);
      for (int k = 0; k < 10; k++) begin
         if (k == 0)                                     t = {mode_tag(seq[k]), " R7"};
         else if (len_of(seq[k]) != len_of(seq[k-1]))  t = {mode_tag(seq[k]), " R8"};
         else                                          t = {mode_tag(seq[k]), " R6"};
         push_cycle(seq[k], t);
      end
      @(posedge clk);
      #1;
      rst = 1'b0;
      mon_en = 1'b1;
      for (int k = 0; k < 10; k++) begin
         wait_idx(10);
         // Mid-cycle change of the selects to a different ratio: must be ignored (R6).
         if (k < 9) {sel_wide, sel_fine} = seq[k+1][1] ? 2'b01 : 2'b10;
         if (k == 3) begin
            clk_en = 1'b0;
            #500;
            check("R9 stalled idx", int'(count_idx), 10);
            check("R9 stalled out", int'(div_out), 0);
            clk_en = 1'b1;
         end
         wait_idx(40);
         if (k < 9) {sel_wide, sel_fine} = seq[k+1];
      end
      while (q.size() > 0) @(negedge clk);

      // Reset in the middle of a cycle, then two cycles at 65.
      mon_en = 1'b0;
      wait_idx(20);
      rst = 1'b1;
      {sel_wide, sel_fine} = 2'b00;
      @(negedge clk);
      check("R7 mid reset idx", int'(count_idx), 1);
      check("R7 mid reset out", int'(div_out), 0);
      @(negedge clk);
      check("R7 held reset idx", int'(count_idx), 1);
      push_cycle(2'b00, "R2 R7");
      push_cycle(2'b00, "R2 R7");
      @(posedge clk);
      #1;
      rst = 1'b0;
      mon_en = 1'b1;
      while (q.size() > 0) @(negedge clk);
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog R4: actual timeout expected completion");
         summary();
         $finish;
      end
   end
endmodule